// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This block carries out one data-processing step of a 32-bit integer core: it takes a 4-bit condition code, a 4-bit operation code, a flag-set request, the first operand value, an already shifted second operand together with the carry out of that shifter, and the current N, Z, C, V flags. It decides whether the condition holds against those flags. When it holds, it produces the operation result, a write strobe for the destination register and the next flag state. When it does not, the step turns into a no-operation.

All three results are captured in registers on the same clock edge, so a caller presents one operation per cycle and picks up its results one cycle later. The caller keeps the architectural flags: it feeds `flags_q` back into `flags_i` (or merges it with its own state) and writes `res_q` to its register file when `wr_en_q` is high. Register storage, mode bits and multiply are handled elsewhere.

Top module: `cond_dp_alu`

## Requirements
- R1: The condition field selects a test on the flags `flags_i` = {N,Z,C,V} (bit 3 = N, bit 0 = V): 0 Z, 1 not Z, 2 C, 3 not C, 4 N, 5 not N, 6 V, 7 not V, 8 C and not Z, 9 not C or Z, 10 N = V, 11 N != V, 12 N = V and not Z, 13 N != V or Z.
- R2: Condition 14 always passes and condition 15 never passes, whatever the flags.
- R3: When the condition fails, `wr_en_q` is 0 and `flags_q` equals the `flags_i` presented with that operation.
- R4: Logical operations: opcode 0 Rn AND Op2, 1 Rn XOR Op2, 12 Rn OR Op2, 13 Op2, 14 Rn AND NOT Op2, 15 NOT Op2; opcodes 13 and 15 give the same result for any Rn.
- R5: Arithmetic operations: opcode 2 Rn - Op2, 3 Op2 - Rn, 4 Rn + Op2, all modulo 2^W.
- R6: Carry-in operations: opcode 5 Rn + Op2 + C, 6 Rn - Op2 - (1 - C), 7 Op2 - Rn - (1 - C), with C taken from `flags_i`.
- R7: Compare opcodes 8 (AND), 9 (XOR), 10 (subtract), 11 (add) never raise `wr_en_q` and update the flags when the condition passes, even with `set_flags_i` = 0.
- R8: For opcodes 0, 1, 8, 9, 12 to 15 with a flag update, N is the result MSB, Z is 1 when the result is zero, C equals `shift_c_i` and V keeps its input value.
- R9: For opcodes 2 to 7, 10, 11 with a flag update, N and Z come from the result, C is the adder carry out (for subtractions 1 means no borrow) and V is signed overflow.
- R10: A passing non-compare operation with `set_flags_i` = 0 raises `wr_en_q` and leaves `flags_q` equal to `flags_i`.
- R11: Results appear on `res_q`, `wr_en_q`, `flags_q` at the first rising clock edge after the inputs; a synchronous reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Condition code |
| opcode_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request a flag update for non-compare operations |
| rn_i | input | W | First operand |
| op2_i | input | W | Shifted second operand |
| shift_c_i | input | 1 | Carry out of the operand shifter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| res_q | output | W | Registered operation result |
| wr_en_q | output | 1 | Registered destination write strobe |
| flags_q | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
Every result of this block, the value, the write strobe and the next flags, is due at the first rising edge after the operation is applied, and none of them depends on any earlier operation. The bench therefore drives each operation on a falling edge, lets exactly one rising edge pass and samples all three outputs on the next falling edge, before any new stimulus. The sweeps run at an 8-bit width so that the operand grid reaches every carry, borrow and overflow boundary, with every condition code crossed with all sixteen flag patterns.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Compare group: flags only, no destination write.
  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  // Operations whose flags come from the adder.
  function automatic logic op_is_arith(input logic [3:0] op);
    return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) ||
           (op == OP_CMP) || (op == OP_CMN);
  endfunction

endpackage

// File: rtl/cdp_cond_eval.sv
module cdp_cond_eval
  import cdp_pkg::*;
(
  input  logic [3:0] cc_i,
  input  nzcv_t      fl_i,
  output logic       pass_o
);

  always_comb begin
    unique case (cc_e'(cc_i))
      CC_EQ:   pass_o = fl_i.z;
      CC_NE:   pass_o = ~fl_i.z;
      CC_CS:   pass_o = fl_i.c;
      CC_CC:   pass_o = ~fl_i.c;
      CC_MI:   pass_o = fl_i.n;
      CC_PL:   pass_o = ~fl_i.n;
      CC_VS:   pass_o = fl_i.v;
      CC_VC:   pass_o = ~fl_i.v;
      CC_HI:   pass_o = fl_i.c & ~fl_i.z;
      CC_LS:   pass_o = ~fl_i.c | fl_i.z;
      CC_GE:   pass_o = fl_i.n ~^ fl_i.v;
      CC_LT:   pass_o = fl_i.n ^ fl_i.v;
      CC_GT:   pass_o = (fl_i.n ~^ fl_i.v) & ~fl_i.z;
      CC_LE:   pass_o = (fl_i.n ^ fl_i.v) | fl_i.z;
      CC_AL:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cdp_adder.sv
module cdp_adder
  import cdp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] op2_i,
  input  logic         c_in_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  localparam int SW = W + 1;

  logic [W-1:0]  opa, opb;
  logic          cin;
  logic [SW-1:0] wide;

  // One adder serves every arithmetic opcode: swap for reverse forms,
  // invert the subtrahend, and pick the carry in.
  always_comb begin
    opa = rn_i;
    opb = op2_i;
    cin = 1'b0;
    unique case (dp_op_e'(op_i))
      OP_SUB, OP_CMP: begin opb = ~op2_i; cin = 1'b1; end
      OP_RSB:         begin opa = op2_i; opb = ~rn_i; cin = 1'b1; end
      OP_ADC:         begin cin = c_in_i; end
      OP_SBC:         begin opb = ~op2_i; cin = c_in_i; end
      OP_RSC:         begin opa = op2_i; opb = ~rn_i; cin = c_in_i; end
      default:        begin cin = 1'b0; end
    endcase
  end

  assign wide   = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
  assign sum_o  = wide[W-1:0];
  assign cout_o = wide[W];
  assign ovf_o  = (opa[W-1] == opb[W-1]) && (wide[W-1] != opa[W-1]);

endmodule

// File: rtl/cdp_logic.sv
module cdp_logic
  import cdp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] op2_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    unique case (dp_op_e'(op_i))
      OP_AND, OP_TST: res_o = rn_i & op2_i;
      OP_EOR, OP_TEQ: res_o = rn_i ^ op2_i;
      OP_ORR:         res_o = rn_i | op2_i;
      OP_MOV:         res_o = op2_i;
      OP_BIC:         res_o = rn_i & ~op2_i;
      OP_MVN:         res_o = ~op2_i;
      default:        res_o = '0;
    endcase
  end

endmodule

// File: rtl/cond_dp_alu.sv
module cond_dp_alu
  import cdp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   cond_i,
  input  logic [3:0]   opcode_i,
  input  logic         set_flags_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] op2_i,
  input  logic         shift_c_i,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] res_q,
  output logic         wr_en_q,
  output logic [3:0]   flags_q
);

  nzcv_t        cur_fl, nxt_fl;
  logic         pass;
  logic [W-1:0] add_res, log_res, res_d;
  logic         add_c, add_v;
  logic         is_arith, is_cmp, do_flags, do_write;

  assign cur_fl = nzcv_t'(flags_i);

  cdp_cond_eval u_cond (
    .cc_i   (cond_i),
    .fl_i   (cur_fl),
    .pass_o (pass)
  );

  cdp_adder #(.W(W)) u_add (
    .op_i   (opcode_i),
    .rn_i   (rn_i),
    .op2_i  (op2_i),
    .c_in_i (cur_fl.c),
    .sum_o  (add_res),
    .cout_o (add_c),
    .ovf_o  (add_v)
  );

  cdp_logic #(.W(W)) u_log (
    .op_i  (opcode_i),
    .rn_i  (rn_i),
    .op2_i (op2_i),
    .res_o (log_res)
  );

  assign is_arith = op_is_arith(opcode_i);
  assign is_cmp   = op_is_compare(opcode_i);
  assign res_d    = is_arith ? add_res : log_res;
  assign do_flags = pass && (set_flags_i || is_cmp);
  assign do_write = pass && !is_cmp;

  always_comb begin
    nxt_fl = cur_fl;
    if (do_flags) begin
      nxt_fl.n = res_d[W-1];
      nxt_fl.z = (res_d == '0);
      nxt_fl.c = is_arith ? add_c : shift_c_i;
      nxt_fl.v = is_arith ? add_v : cur_fl.v;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      wr_en_q <= 1'b0;
      flags_q <= '0;
    end else begin
      res_q   <= res_d;
      wr_en_q <= do_write;
      flags_q <= nxt_fl;
    end
  end

  // R2: never-condition blocks the write
  p_nv_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'hF) |=> !wr_en_q);

  // R3: failed condition keeps the flags
  p_fail_keeps_flags_r3: assert property (@(posedge clk) disable iff (rst)
    !pass |=> (flags_q == $past(flags_i)));

  // R7: compares never write
  p_cmp_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (opcode_i[3:2] == 2'b10) |=> !wr_en_q);

  // R8: logical operations keep V
  p_logic_keeps_v_r8: assert property (@(posedge clk) disable iff (rst)
    !is_arith |=> (flags_q[0] == $past(flags_i[0])));

  // R10: no set request on a non-compare keeps the flags
  p_nos_keeps_flags_r10: assert property (@(posedge clk) disable iff (rst)
    (!set_flags_i && !is_cmp) |=> (flags_q == $past(flags_i)));

endmodule

// File: tb/test_cond_dp_alu.sv
module test_cond_dp_alu;

  localparam int W    = 8;
  localparam int MASK = (1 << W) - 1;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));

  logic         clk = 1'b0;
  logic         rst;
  logic [3:0]   cond_i, opcode_i, flags_i;
  logic         set_flags_i, shift_c_i;
  logic [W-1:0] rn_i, op2_i;
  logic [W-1:0] res_q;
  logic         wr_en_q;
  logic [3:0]   flags_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cond_dp_alu #(.W(W)) i_cond_dp_alu (
    .clk(clk), .rst(rst), .cond_i(cond_i), .opcode_i(opcode_i),
    .set_flags_i(set_flags_i), .rn_i(rn_i), .op2_i(op2_i),
    .shift_c_i(shift_c_i), .flags_i(flags_i),
    .res_q(res_q), .wr_en_q(wr_en_q), .flags_q(flags_q)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit cond_ok(input int cc, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c && !z;    9: return !c || z;
      10: return n == v;    11: return n != v;
      12: return (n == v) && !z;
      13: return (n != v) || z;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int sx(input int x);
    return (x > SMAX) ? x - (1 << W) : x;
  endfunction

  // Applies one operation and checks all three outputs one edge later.
  task automatic run_op(input int cc, input int op, input bit s, input int rn,
                        input int b, input bit sc, input logic [3:0] f,
                        input string tag);
    int  r, sr, a_s, b_s, rm;
    bit  c, pass, arith, sub, cmp;
    logic [3:0] ef;
    c     = f[1];
    sub   = (op == 2) || (op == 3) || (op == 6) || (op == 7) || (op == 10);
    arith = sub || (op == 4) || (op == 5) || (op == 11);
    cmp   = (op >= 8) && (op <= 11);
    a_s   = sx(rn);
    b_s   = sx(b);
    sr    = 0;
    case (op)
      0, 8:  r = rn & b;
      1, 9:  r = rn ^ b;
      2, 10: begin r = rn - b;           sr = a_s - b_s;           end
      3:     begin r = b - rn;           sr = b_s - a_s;           end
      4, 11: begin r = rn + b;           sr = a_s + b_s;           end
      5:     begin r = rn + b + c;       sr = a_s + b_s + c;       end
      6:     begin r = rn - b - (1 - c); sr = a_s - b_s - (1 - c); end
      7:     begin r = b - rn - (1 - c); sr = b_s - a_s - (1 - c); end
      12:    r = rn | b;
      13:    r = b;
      14:    r = rn & ~b;
      default: r = ~b;
    endcase
    rm   = r & MASK;
    pass = cond_ok(cc, f);
    ef   = f;
    if (pass && (s || cmp)) begin
      ef[3] = rm[W-1];
      ef[2] = (rm == 0);
      if (arith) begin
        ef[1] = sub ? (r >= 0) : (r > MASK);
        ef[0] = (sr > SMAX) || (sr < SMIN);
      end else begin
        ef[1] = sc;
      end
    end
    @(negedge clk);
    cond_i = 4'(cc); opcode_i = 4'(op); set_flags_i = s;
    rn_i = W'(rn); op2_i = W'(b); shift_c_i = sc; flags_i = f;
    @(negedge clk);
    check({tag, " write"}, int'(wr_en_q), int'(pass && !cmp));
    check({tag, " flags"}, int'(flags_q), int'(ef));
    if (pass && !cmp) check({tag, " result"}, int'(res_q), rm);
  endtask

  function automatic string op_tag(input int op, input bit s);
    if (op >= 8 && op <= 11) return "R7";
    if (!s) return "R10";
    if (op == 5 || op == 6 || op == 7) return "R6";
    if (op >= 2 && op <= 4) return "R5/R9";
    return "R4/R8";
  endfunction

  int vals[12] = '{0, 1, 2, 'h3F, 'h40, 'h7E, 'h7F, 'h80, 'h81, 'hC0, 'hFE, 'hFF};

  initial begin
    rst = 1'b1; cond_i = 4'hE; opcode_i = 4'hD; set_flags_i = 1'b0;
    rn_i = '0; op2_i = '0; shift_c_i = 1'b0; flags_i = 4'hF;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset res", int'(res_q), 0);
    check("R11 reset write", int'(wr_en_q), 0);
    check("R11 reset flags", int'(flags_q), 0);
    rst = 1'b0;

    // R1 R2 R3: every condition against every flag pattern
    for (int cc = 0; cc < 16; cc++)
      for (int fv = 0; fv < 16; fv++)
        run_op(cc, 13, 1'b1, 'h55, 'h80, 1'b1, 4'(fv),
               (cc >= 14) ? "R2" : (cond_ok(cc, 4'(fv)) ? "R1" : "R1/R3"));

    // R3: failing condition with a compare and a carry-in subtract
    run_op(0, 10, 1'b1, 5, 9, 1'b0, 4'b0000, "R3");
    run_op(15, 6, 1'b1, 1, 2, 1'b1, 4'b1011, "R3");

    // R4: MOV and MVN ignore Rn (same result for two Rn values)
    run_op(14, 13, 1'b0, 'h00, 'h5A, 1'b0, 4'b0000, "R4");
    run_op(14, 13, 1'b0, 'hFF, 'h5A, 1'b0, 4'b0000, "R4");
    run_op(14, 15, 1'b0, 'h00, 'h5A, 1'b0, 4'b0000, "R4");
    run_op(14, 15, 1'b0, 'hFF, 'h5A, 1'b0, 4'b0000, "R4");

    // R4..R10: all opcodes over the operand grid, carry in, shifter carry, V in
    for (int op = 0; op < 16; op++)
      for (int s = 0; s < 2; s++)
        for (int ci = 0; ci < 2; ci++)
          for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
              run_op(14, op, s[0], vals[i], vals[j], (i + j + ci) % 2 == 1,
                     {1'b0, 1'b0, ci[0], ((i ^ j) & 1) == 1}, op_tag(op, s[0]));

    // R11: reset clears outputs after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 re-reset write", int'(wr_en_q), 0);
    check("R11 re-reset flags", int'(flags_q), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule